// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block is a real-time clock peripheral. It keeps a count of whole seconds in a 32-bit register and raises an interrupt when that count reaches a value that software has programmed. An external prescaler supplies a single-cycle strobe once per second. The counter moves only on that strobe, and only while the run bit of the control register is set.

Software uses a plain 32-bit register bus with single-cycle read and write strobes and a byte address. Read data is combinational and valid in the cycle that the read strobe is high. A value written to the load register is held as a staged value. It replaces the count at the next enabled one-second strobe, not at the write. The match interrupt has two gates. An enable bit passes it and a mask bit blocks it. Software can see both the raw flag and the gated flag. Reading the end-of-interrupt register clears the raw flag.

None of the interfaces carries a data stream, so there is no valid/ready handshake. Every pin is a plain strobe or level.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the count, match, control, load and both status views read 0 and `irq_o` is low.
- R2: On each `tick_i` cycle with control bit 2 (run) set, the count goes up by one, wrapping from 0xFFFFFFFF to 0. With run clear, or with no tick, the count holds.
- R3: A write to the load register (offset 0x08) leaves the count unchanged. The value is applied at the next tick that has run set, in place of the increment. With run clear, the load keeps waiting. Reading offset 0x08 returns the last value written.
- R4: The raw flag is set on an enabled tick when the new count (incremented or loaded) equals the match register (offset 0x04). It stays set until it is cleared.
- R5: A read of offset 0x18 returns 0 and clears the raw flag. If a setting tick falls in the same cycle as that read, the set wins.
- R6: `irq_o` = raw AND control bit 0 (enable) AND NOT control bit 1 (mask). Bit 0 of offset 0x10 shows `irq_o` and bit 0 of offset 0x14 shows the raw flag.
- R7: The match register and control bits [3:0] read back what was written, with control bits above 3 reading 0. Offset 0x00 returns the count and offset 0x1C returns the VERSION parameter.
- R8: Writes to offsets 0x00, 0x10, 0x14, 0x18 and 0x1C have no effect. Reads of offsets beyond 0x1C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid while rd_en_i is high |
| irq_o | output | 1 | Gated match interrupt |

## Verification
The bound checker watches the cycle-level rules on every cycle. The count never moves without an enabled tick, and it steps by exactly one or takes the staged value. The raw flag rises only on an enabled tick and falls only after an end-of-interrupt read. The interrupt is never high without the raw flag. The directed scenarios are the only evidence for register readback, the wrap to zero, a load that waits across a stopped counter, the set-wins collision with an end-of-interrupt read, and the fact that writes to read-only and unmapped locations do nothing.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  // word indices (byte offset / 4)
  localparam int W_COUNT = 0;
  localparam int W_MATCH = 1;
  localparam int W_LOAD  = 2;
  localparam int W_CTRL  = 3;
  localparam int W_MSTAT = 4;
  localparam int W_RSTAT = 5;
  localparam int W_EOI   = 6;
  localparam int W_VER   = 7;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic wake;  // bit 3, storage only
    logic run;   // bit 2
    logic mask;  // bit 1
    logic ie;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              step_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] next_o,
  output logic [DATA_W-1:0] stage_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] cnt_q, stage_q;
  logic              pend_q;

  // staged value takes priority over the increment on a step
  assign next_o = pend_q ? stage_q : cnt_q + DATA_W'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cnt_q   <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (step_i) cnt_q <= next_o;
      if (load_wr_i) begin
        stage_q <= load_val_i;
        pend_q  <= 1'b1;          // a fresh write stays pending
      end else if (step_i) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign count_o = cnt_q;
  assign stage_o = stage_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/rtc_match_irq.sv
module rtc_match_irq #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] next_cnt_i,
  input  logic [DATA_W-1:0] match_i,
  input  logic              eoi_i,
  input  logic              ie_i,
  input  logic              mask_i,
  output logic              raw_o,
  output logic              irq_o
);
  logic raw_q;
  logic hit;

  assign hit = step_i && (next_cnt_i == match_i);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i)   raw_q <= 1'b0;
    else if (hit)   raw_q <= 1'b1;   // set beats clear
    else if (eoi_i) raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & ie_i & ~mask_i;
endmodule

// File: rtl/rtc_reg_if.sv
module rtc_reg_if
  import sec_rtc_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 6,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] stage_i,
  input  logic              raw_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] match_o,
  output ctrl_t             ctrl_o,
  output logic              load_wr_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              eoi_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] match_q;
  ctrl_t             ctrl_q;

  assign word = addr_i[ADDR_W-1:2];

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      match_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_en_i) begin
      if (word == WORD_W'(W_MATCH)) match_q <= wdata_i;
      if (word == WORD_W'(W_CTRL))  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  assign load_wr_o  = wr_en_i && (word == WORD_W'(W_LOAD));
  assign load_val_o = wdata_i;
  assign eoi_o      = rd_en_i && (word == WORD_W'(W_EOI));

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (word == WORD_W'(W_COUNT)) rdata_o = count_i;
      if (word == WORD_W'(W_MATCH)) rdata_o = match_q;
      if (word == WORD_W'(W_LOAD))  rdata_o = stage_i;
      if (word == WORD_W'(W_CTRL))  rdata_o = DATA_W'(ctrl_q);
      if (word == WORD_W'(W_MSTAT)) rdata_o = DATA_W'(irq_i);
      if (word == WORD_W'(W_RSTAT)) rdata_o = DATA_W'(raw_i);
      if (word == WORD_W'(W_VER))   rdata_o = DATA_W'(VERSION);
    end
  end

  assign match_o = match_q;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 6,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_w, next_w, stage_w, match_w, load_val_w;
  logic              pend_w, raw_w, load_wr_w, eoi_w, step_w;
  ctrl_t             ctrl_w;

  assign step_w = tick_i & ctrl_w.run;

  rtc_reg_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_n_i, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .count_i(cnt_w), .stage_i(stage_w), .raw_i(raw_w), .irq_i(irq_o),
    .rdata_o, .match_o(match_w), .ctrl_o(ctrl_w),
    .load_wr_o(load_wr_w), .load_val_o(load_val_w), .eoi_o(eoi_w)
  );

  rtc_seconds_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_n_i, .step_i(step_w),
    .load_wr_i(load_wr_w), .load_val_i(load_val_w),
    .count_o(cnt_w), .next_o(next_w), .stage_o(stage_w), .pend_o(pend_w)
  );

  rtc_match_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i, .rst_n_i, .step_i(step_w), .next_cnt_i(next_w),
    .match_i(match_w), .eoi_i(eoi_w),
    .ie_i(ctrl_w.ie), .mask_i(ctrl_w.mask),
    .raw_o(raw_w), .irq_o
  );
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              tick_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              run,
  input logic              pend,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] stage,
  input logic              raw,
  input logic              irq_o
);
  logic eoi_rd, en_tick;
  assign eoi_rd  = rd_en_i && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(6));
  assign en_tick = tick_i && run;

  // R2: count holds without an enabled tick
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !en_tick |=> $stable(count));
  // R2: plain step adds one
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_tick && !pend) |=> count == $past(count) + DATA_W'(1));
  // R3: pending load replaces the increment
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_tick && pend) |=> count == $past(stage));
  // R4: raw rises only on an enabled tick
  a_r4_rise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(raw) |-> $past(en_tick));
  // R5: raw falls only after an end-of-interrupt read
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(raw) |-> $past(eoi_rd));
  // R6: interrupt needs the raw flag
  a_r6_gate: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    irq_o |-> raw);
endmodule

bind sec_rtc sec_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(tick_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .run(ctrl_w.run), .pend(pend_w), .count(cnt_w),
  .stage(stage_w), .raw(raw_w), .irq_o(irq_o)
);

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
  localparam int          DW  = 32;
  localparam int          AW  = 6;
  localparam logic [31:0] VER = 32'h0001_0200;
  localparam logic [AW-1:0] A_CNT = 6'h00, A_MATCH = 6'h04, A_LOAD = 6'h08,
    A_CTRL = 6'h0C, A_MST = 6'h10, A_RST = 6'h14, A_EOI = 6'h18, A_VER = 6'h1C;

  logic          clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sec_rtc #(.DATA_W(DW), .ADDR_W(AW), .VERSION(VER)) u_sec_rtc (
    .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic expect_rd(string req, logic [AW-1:0] a, logic [DW-1:0] e);
    logic [DW-1:0] d;
    rd(a, d); check(req, d, e);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset;
    expect_rd("R1 count", A_CNT, 0);
    expect_rd("R1 ctrl", A_CTRL, 0);
    expect_rd("R1 match", A_MATCH, 0);
    expect_rd("R1 load", A_LOAD, 0);
    expect_rd("R1 raw", A_RST, 0);
    expect_rd("R1 masked", A_MST, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map;
    wr(A_MATCH, 32'hDEAD_0000); expect_rd("R7 match", A_MATCH, 32'hDEAD_0000);
    wr(A_CTRL, 32'hA);          expect_rd("R7 ctrl", A_CTRL, 32'hA);
    wr(A_CTRL, 32'hFFFF_FFF0);  expect_rd("R7 ctrl upper", A_CTRL, 0);
    expect_rd("R7 version", A_VER, VER);
  endtask

  task automatic t_stopped;
    pulse(3); expect_rd("R2 stopped", A_CNT, 0);
  endtask

  task automatic t_count;
    wr(A_CTRL, 32'h4); pulse(3); expect_rd("R2 step", A_CNT, 3);
  endtask

  task automatic t_deferred;
    wr(A_LOAD, 100);
    expect_rd("R3 deferred", A_CNT, 3);
    expect_rd("R3 load readback", A_LOAD, 100);
    pulse(1); expect_rd("R3 applied", A_CNT, 100);
    pulse(1); expect_rd("R3 after", A_CNT, 101);
  endtask

  task automatic t_load_stopped;
    wr(A_CTRL, 0); wr(A_LOAD, 50); pulse(1);
    expect_rd("R3 waits while stopped", A_CNT, 101);
    wr(A_CTRL, 32'h4); pulse(1);
    expect_rd("R3 applied on run", A_CNT, 50);
  endtask

  task automatic t_match;
    wr(A_MATCH, 52); wr(A_CTRL, 32'h5);
    pulse(1); expect_rd("R4 no early raw", A_RST, 0);
    check("R6 no early irq", 32'(irq), 0);
    pulse(1); expect_rd("R4 raw set", A_RST, 1);
    check("R6 irq", 32'(irq), 1);
    expect_rd("R6 masked view", A_MST, 1);
    pulse(1); expect_rd("R4 sticky", A_RST, 1);
  endtask

  task automatic t_mask;
    wr(A_CTRL, 32'h7);
    check("R6 mask irq", 32'(irq), 0);
    expect_rd("R6 masked view low", A_MST, 0);
    expect_rd("R6 raw view high", A_RST, 1);
    wr(A_CTRL, 32'h4); check("R6 enable off", 32'(irq), 0);
    wr(A_CTRL, 32'h5); check("R6 re-enabled", 32'(irq), 1);
  endtask

  task automatic t_eoi;
    logic [DW-1:0] d;
    expect_rd("R5 eoi data", A_EOI, 0);
    expect_rd("R5 cleared", A_RST, 0);
    check("R5 irq low", 32'(irq), 0);
    // count 53 -> 54, then collide setting tick (55) with eoi read
    wr(A_MATCH, 55); pulse(1);
    @(negedge clk); tick = 1; rd_en = 1; addr = A_EOI; #1 d = rdata;
    @(negedge clk); tick = 0; rd_en = 0;
    expect_rd("R5 set wins", A_RST, 1);
    rd(A_EOI, d);
  endtask

  task automatic t_load_match;
    logic [DW-1:0] d;
    wr(A_MATCH, 200); wr(A_LOAD, 200); pulse(1);
    expect_rd("R4 match on loaded", A_RST, 1);
    rd(A_EOI, d);
  endtask

  task automatic t_wrap;
    wr(A_LOAD, 32'hFFFF_FFFF); pulse(1);
    expect_rd("R2 at max", A_CNT, 32'hFFFF_FFFF);
    pulse(1); expect_rd("R2 wrap", A_CNT, 0);
  endtask

  task automatic t_readonly;
    wr(A_MATCH, 1); pulse(1);
    expect_rd("R8 raw set", A_RST, 1);
    wr(A_EOI, 32'h1);  expect_rd("R8 eoi write ignored", A_RST, 1);
    wr(A_RST, 0);      expect_rd("R8 raw write ignored", A_RST, 1);
    wr(A_MST, 0);      check("R8 masked write ignored", 32'(irq), 1);
    wr(A_CNT, 32'h1234); expect_rd("R8 count write ignored", A_CNT, 1);
    wr(A_VER, 0);      expect_rd("R8 version write ignored", A_VER, VER);
    expect_rd("R8 unmapped 0x20", 6'h20, 0);
    expect_rd("R8 unmapped 0x3C", 6'h3C, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_map(); t_stopped(); t_count(); t_deferred();
    t_load_stopped(); t_match(); t_mask(); t_eoi(); t_load_match();
    t_wrap(); t_readonly();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule